// File: doc/BRIEF.md
# Multi-Address I2C Target Front End

This block is the bus-facing front end of an I2C target. It watches the two synchronized bus lines, finds START and STOP conditions, shifts in the first byte of every transfer and compares its upper seven bits against four programmable target addresses. On a hit it answers the acknowledge bit with a level chosen by software. It also records the direction bit in the matching address register, sets a sticky match flag and, if allowed, raises an interrupt. After that it either collects written bytes or shifts out a transmit byte for reads.

Software reaches the block through a small 16-bit register bus. There are four address registers at offsets 0 to 3, a control register at 4, a status register at 5 and one data buffer at 6. The data buffer has separate transmit and receive storage. Writes go to the transmit byte and reads return the last byte received. Register reads return data one clock after the read strobe.

Top module: `i2c_mt_top`

## Requirements
- R1: After reset, slot register 0 reads 0x0036 (address 0x1B, mode bit 0), slot registers 1 to 3 read 0x0000, control and status read 0x0000, and `irq` is 0.
- R2: Slot registers keep bits 7:1 as the 7-bit address and bit 0 as the mode bit, both writable; bits 15:8 of every register read as zero.
- R3: Slot 0 always takes part in matching; slot k (k = 1..3) takes part only when control bit k-1 is 1.
- R4: When several enabled slots hold the received address, the lowest-numbered one wins, and its number is reported in status bits 2:1.
- R5: On a match, SDA during the address acknowledge bit carries control bit 3 (0 pulls SDA low = ACK, 1 releases it). With no match, SDA is released for that bit and the bus is ignored until the next START.
- R6: On a match, bit 0 of the winning slot register takes the received R/W bit and no other slot register changes.
- R7: A match sets status bit 0. Writing 1 to status bit 0 clears it, writing 0 has no effect, and a match in the same cycle as a clear leaves it set.
- R8: `irq` is high exactly while status bit 0 and control bit 4 (match interrupt enable) are both 1, delayed by one clock.
- R9: A write to offset 6 loads the transmit byte; a read of offset 6 returns the last received data byte, not the transmit byte. Received data bytes are acknowledged with control bit 3.
- R10: In an acknowledged read transfer the transmit byte is sent MSB first and repeated after each master ACK; after a master NACK SDA stays released until the next START.
- R11: A STOP returns the block to idle and releases SDA, so bytes clocked afterwards without a START get no acknowledge and are not stored. An address answered with control bit 3 = 1 starts no data phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | I2C clock line, asynchronous |
| sda_i | input | 1 | I2C data line as seen on the wire, asynchronous |
| sda_oe | output | 1 | 1 pulls SDA low, 0 releases it |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 3 | Register offset |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Register read data, valid the clock after `reg_rd` |
| irq | output | 1 | Match interrupt |

## Verification
The assertions assume a well-behaved bus master. SDA changes only while SCL is low, except for START and STOP. Each SCL phase lasts several system clocks longer than the synchronizer delay, so the block can drive or release SDA before the next rising edge. The bench's master tasks hold each SCL phase for eight clocks. They change their own SDA only in the low phase, and they end every read with a NACK before a STOP, so the block is never holding SDA low when a STOP is generated.

// File: rtl/i2c_mt_pkg.sv
package i2c_mt_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_ADDR, ST_AACK, ST_RX, ST_WACK, ST_TX, ST_MACK, ST_IGN
  } tgt_state_e;
endpackage

// File: rtl/i2c_mt_sync.sv
module i2c_mt_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);
  logic [STAGES-1:0] scl_ch, sda_ch;
  logic scl_p, sda_p, scl_s;

  always_ff @(posedge clk) begin
    if (rst) begin
      scl_ch <= '1;
      sda_ch <= '1;
      scl_p  <= 1'b1;
      sda_p  <= 1'b1;
    end else begin
      scl_ch <= {scl_ch[STAGES-2:0], scl_i};
      sda_ch <= {sda_ch[STAGES-2:0], sda_i};
      scl_p  <= scl_ch[STAGES-1];
      sda_p  <= sda_ch[STAGES-1];
    end
  end

  assign scl_s     = scl_ch[STAGES-1];
  assign sda_s     = sda_ch[STAGES-1];
  assign scl_rise  = scl_s & ~scl_p;
  assign scl_fall  = ~scl_s & scl_p;
  // START: SDA falls while SCL high; STOP: SDA rises while SCL high (R11)
  assign start_det = scl_s & scl_p & sda_p & ~sda_s;
  assign stop_det  = scl_s & scl_p & ~sda_p & sda_s;
endmodule

// File: rtl/i2c_mt_match.sv
module i2c_mt_match #(
  parameter int NSLOT = 4,
  parameter int AW    = 7,
  parameter int IW    = 2
) (
  input  logic [NSLOT-1:0][AW-1:0] slot_addr,
  input  logic [NSLOT-1:0]         slot_en,
  input  logic [AW-1:0]            probe,
  output logic                     hit,
  output logic [IW-1:0]            idx
);
  logic [NSLOT-1:0] eq;

  genvar gi;
  generate
    for (gi = 0; gi < NSLOT; gi++) begin : g_cmp
      assign eq[gi] = slot_en[gi] && (slot_addr[gi] == probe);
    end
  endgenerate

  // lowest index wins (R4)
  always_comb begin
    hit = |eq;
    idx = '0;
    for (int i = NSLOT - 1; i >= 0; i--) begin
      if (eq[i]) idx = IW'(i);
    end
  end
endmodule

// File: rtl/i2c_mt_engine.sv
module i2c_mt_engine
  import i2c_mt_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          sda_s,
  input  logic          scl_rise,
  input  logic          scl_fall,
  input  logic          start_det,
  input  logic          stop_det,
  input  logic          hit,
  input  logic          ack_val,
  input  logic [DW-1:0] tx_byte,
  output logic [DW-2:0] probe,
  output logic          match_evt,
  output logic          rw_bit,
  output logic [DW-1:0] rx_byte,
  output logic          sda_oe
);
  localparam int CW = $clog2(DW) + 1;

  tgt_state_e    st;
  logic [CW-1:0] cnt;
  logic [DW-1:0] shreg, txsr;
  logic          done, acked, macked;

  assign probe = shreg[DW-1:1];

  always_ff @(posedge clk) begin
    if (rst) begin
      st        <= ST_IDLE;
      cnt       <= '0;
      shreg     <= '0;
      txsr      <= '0;
      done      <= 1'b0;
      acked     <= 1'b0;
      macked    <= 1'b0;
      match_evt <= 1'b0;
      rw_bit    <= 1'b0;
      rx_byte   <= '0;
      sda_oe    <= 1'b0;
    end else begin
      match_evt <= 1'b0;
      if (start_det) begin
        st     <= ST_ADDR;
        cnt    <= '0;
        done   <= 1'b0;
        sda_oe <= 1'b0;
      end else if (stop_det) begin
        st     <= ST_IDLE;
        done   <= 1'b0;
        sda_oe <= 1'b0;
      end else begin
        unique case (st)
          ST_ADDR, ST_RX: begin
            if (scl_rise) begin
              shreg <= {shreg[DW-2:0], sda_s};
              cnt   <= cnt + 1'b1;
              done  <= (cnt == CW'(DW - 1));
            end else if (scl_fall && done) begin
              done <= 1'b0;
              cnt  <= '0;
              if (st == ST_ADDR) begin
                if (hit) begin
                  match_evt <= 1'b1;
                  rw_bit    <= shreg[0];
                  acked     <= ~ack_val;
                  sda_oe    <= ~ack_val;   // R5
                  st        <= ST_AACK;
                end else begin
                  st <= ST_IGN;            // R5: NACK by release
                end
              end else begin
                rx_byte <= shreg;          // R9
                acked   <= ~ack_val;
                sda_oe  <= ~ack_val;
                st      <= ST_WACK;
              end
            end
          end
          ST_AACK: begin
            if (scl_fall) begin
              if (!acked) begin
                sda_oe <= 1'b0;            // R11: no data phase
                st     <= ST_IGN;
              end else if (rw_bit) begin
                txsr   <= tx_byte;
                sda_oe <= ~tx_byte[DW-1];  // R10: MSB first
                cnt    <= '0;
                st     <= ST_TX;
              end else begin
                sda_oe <= 1'b0;
                st     <= ST_RX;
              end
            end
          end
          ST_WACK: begin
            if (scl_fall) begin
              sda_oe <= 1'b0;
              st     <= acked ? ST_RX : ST_IGN;
            end
          end
          ST_TX: begin
            if (scl_rise) begin
              cnt  <= cnt + 1'b1;
              done <= (cnt == CW'(DW - 1));
            end else if (scl_fall) begin
              if (done) begin
                done   <= 1'b0;
                cnt    <= '0;
                sda_oe <= 1'b0;
                st     <= ST_MACK;
              end else begin
                txsr   <= {txsr[DW-2:0], 1'b0};
                sda_oe <= ~txsr[DW-2];
              end
            end
          end
          ST_MACK: begin
            if (scl_rise) begin
              macked <= ~sda_s;
            end else if (scl_fall) begin
              if (macked) begin
                txsr   <= tx_byte;
                sda_oe <= ~tx_byte[DW-1];
                st     <= ST_TX;
              end else begin
                sda_oe <= 1'b0;            // R10: master NACK ends it
                st     <= ST_IGN;
              end
            end
          end
          default: begin
            sda_oe <= 1'b0;
          end
        endcase
      end
    end
  end
endmodule

// File: rtl/i2c_mt_top.sv
module i2c_mt_top #(
  parameter int         NSLOT     = 4,
  parameter int         DW        = 8,
  parameter int         RDW       = 16,
  parameter int         RAW       = 3,
  parameter int         SYNC      = 2,
  parameter logic [7:0] SLOT0_RST = 8'h36
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           scl_i,
  input  logic           sda_i,
  output logic           sda_oe,
  input  logic           reg_wr,
  input  logic           reg_rd,
  input  logic [RAW-1:0] reg_addr,
  input  logic [RDW-1:0] reg_wdata,
  output logic [RDW-1:0] reg_rdata,
  output logic           irq
);
  localparam int IW       = $clog2(NSLOT);
  localparam int AW       = DW - 1;
  localparam int CTRL_ACK = NSLOT - 1;
  localparam int CTRL_IE  = NSLOT;
  localparam int CTW      = NSLOT + 1;
  localparam int OFF_CTRL = NSLOT;
  localparam int OFF_STAT = NSLOT + 1;
  localparam int OFF_DATA = NSLOT + 2;

  logic [NSLOT-1:0][DW-1:0] slot_q;
  logic [NSLOT-1:0][AW-1:0] slot_addr;
  logic [NSLOT-1:0]         slot_en;
  logic [CTW-1:0]           ctrl_q;
  logic                     flag_q;
  logic [IW-1:0]            idx_q;
  logic [DW-1:0]            tx_q, rx_byte;
  logic [AW-1:0]            probe;
  logic                     hit, match_evt, rw_bit;
  logic [IW-1:0]            hit_idx;
  logic                     sda_s, scl_rise, scl_fall, start_det, stop_det;
  logic                     ie;
  logic                     unused_wdata;

  assign unused_wdata = ^reg_wdata[RDW-1:DW];
  assign ie           = ctrl_q[CTRL_IE];

  genvar gi;
  generate
    for (gi = 0; gi < NSLOT; gi++) begin : g_slot
      assign slot_addr[gi] = slot_q[gi][DW-1:1];
    end
  endgenerate
  // slot 0 always enabled (R3)
  assign slot_en = {ctrl_q[NSLOT-2:0], 1'b1};

  i2c_mt_sync #(.STAGES(SYNC)) u_sync (
    .clk(clk), .rst(rst), .scl_i(scl_i), .sda_i(sda_i),
    .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_det(start_det), .stop_det(stop_det)
  );

  i2c_mt_match #(.NSLOT(NSLOT), .AW(AW), .IW(IW)) u_match (
    .slot_addr(slot_addr), .slot_en(slot_en), .probe(probe),
    .hit(hit), .idx(hit_idx)
  );

  i2c_mt_engine #(.DW(DW)) u_eng (
    .clk(clk), .rst(rst), .sda_s(sda_s), .scl_rise(scl_rise),
    .scl_fall(scl_fall), .start_det(start_det), .stop_det(stop_det),
    .hit(hit), .ack_val(ctrl_q[CTRL_ACK]), .tx_byte(tx_q),
    .probe(probe), .match_evt(match_evt), .rw_bit(rw_bit),
    .rx_byte(rx_byte), .sda_oe(sda_oe)
  );

  // register file
  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NSLOT; i++) slot_q[i] <= (i == 0) ? SLOT0_RST : '0;
      ctrl_q <= '0;
      flag_q <= 1'b0;
      idx_q  <= '0;
      tx_q   <= '0;
      irq    <= 1'b0;
    end else begin
      if (reg_wr) begin
        for (int i = 0; i < NSLOT; i++) begin
          if (reg_addr == RAW'(i)) slot_q[i] <= reg_wdata[DW-1:0];
        end
        if (reg_addr == RAW'(OFF_CTRL)) ctrl_q <= reg_wdata[CTW-1:0];
        if (reg_addr == RAW'(OFF_STAT) && reg_wdata[0]) flag_q <= 1'b0;
        if (reg_addr == RAW'(OFF_DATA)) tx_q <= reg_wdata[DW-1:0];
      end
      if (match_evt) begin
        slot_q[hit_idx][0] <= rw_bit;   // R6
        idx_q              <= hit_idx;  // R4
        flag_q             <= 1'b1;     // R7: set wins over clear
      end
      irq <= flag_q & ie;               // R8
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      reg_rdata <= '0;
    end else if (reg_rd) begin
      reg_rdata <= '0;
      for (int i = 0; i < NSLOT; i++) begin
        if (reg_addr == RAW'(i)) reg_rdata <= RDW'(slot_q[i]);
      end
      if (reg_addr == RAW'(OFF_CTRL)) reg_rdata <= RDW'(ctrl_q);
      if (reg_addr == RAW'(OFF_STAT)) reg_rdata <= RDW'({idx_q, flag_q});
      if (reg_addr == RAW'(OFF_DATA)) reg_rdata <= RDW'(rx_byte);
    end
  end
endmodule

// File: rtl/i2c_mt_checker.sv
module i2c_mt_checker #(
  parameter int RDW = 16
) (
  input logic           clk,
  input logic           rst,
  input logic           sda_oe,
  input logic           irq,
  input logic [RDW-1:0] reg_rdata,
  input logic           start_det,
  input logic           stop_det,
  input logic           match_evt,
  input logic           flag_q,
  input logic           ie
);
  // R2: upper byte of every register reads zero
  a_r2_upper_zero: assert property (@(posedge clk) disable iff (rst)
    reg_rdata[RDW-1:8] == 8'h00);

  // R11: STOP releases the data line
  a_r11_stop_release: assert property (@(posedge clk) disable iff (rst)
    stop_det |=> !sda_oe);

  // R5: START releases the data line before the address phase
  a_r5_start_release: assert property (@(posedge clk) disable iff (rst)
    start_det |=> !sda_oe);

  // R7: a match always leaves the flag set
  a_r7_flag_set: assert property (@(posedge clk) disable iff (rst)
    match_evt |=> flag_q);

  // R8: interrupt only follows an enabled, set flag
  a_r8_irq_source: assert property (@(posedge clk) disable iff (rst)
    $rose(irq) |-> $past(flag_q && ie));
endmodule

bind i2c_mt_top i2c_mt_checker #(.RDW(RDW)) u_chk (
  .clk(clk), .rst(rst), .sda_oe(sda_oe), .irq(irq), .reg_rdata(reg_rdata),
  .start_det(start_det), .stop_det(stop_det), .match_evt(match_evt),
  .flag_q(flag_q), .ie(ie)
);

// File: tb/tb_i2c_mt_top.sv
module tb_i2c_mt_top;
  localparam int HB = 8;
  localparam logic [2:0] O_CTRL = 3'd4, O_STAT = 3'd5, O_DATA = 3'd6;
  // {addr[6:0], rw, en[2:0], ackval, exp_ack, exp_flag, exp_idx[1:0]}
  localparam int NV = 9;
  localparam logic [15:0] VEC [NV] = '{
    {7'h1B, 1'b0, 3'd0, 1'b0, 1'b1, 1'b1, 2'd0},
    {7'h50, 1'b0, 3'd0, 1'b0, 1'b0, 1'b0, 2'd0},
    {7'h50, 1'b0, 3'd1, 1'b0, 1'b1, 1'b1, 2'd1},
    {7'h50, 1'b0, 3'd2, 1'b0, 1'b1, 1'b1, 2'd2},
    {7'h50, 1'b0, 3'd3, 1'b0, 1'b1, 1'b1, 2'd1},
    {7'h22, 1'b0, 3'd3, 1'b0, 1'b0, 1'b0, 2'd0},
    {7'h22, 1'b0, 3'd4, 1'b0, 1'b1, 1'b1, 2'd3},
    {7'h1B, 1'b0, 3'd0, 1'b1, 1'b0, 1'b1, 2'd0},
    {7'h7F, 1'b0, 3'd7, 1'b0, 1'b0, 1'b0, 2'd0}
  };

  logic clk = 1'b0, rst = 1'b1;
  logic scl_m = 1'b1, sda_m = 1'b1;
  logic sda_oe, irq, bus_sda;
  logic reg_wr = 1'b0, reg_rd = 1'b0;
  logic [2:0] reg_addr = '0;
  logic [15:0] reg_wdata = '0, reg_rdata;
  int errors = 0, checks = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;
  assign bus_sda = sda_m & ~sda_oe;

  i2c_mt_top dut (
    .clk(clk), .rst(rst), .scl_i(scl_m), .sda_i(bus_sda), .sda_oe(sda_oe),
    .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq)
  );

  task automatic wclk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic rwrite(input logic [2:0] a, input logic [15:0] d);
    @(negedge clk); reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_wr = 1'b0;
  endtask

  task automatic rread(input logic [2:0] a, output logic [15:0] d);
    @(negedge clk); reg_rd = 1'b1; reg_addr = a;
    @(negedge clk); reg_rd = 1'b0; d = reg_rdata;
  endtask

  task automatic i_start();
    sda_m = 1'b1; scl_m = 1'b1; wclk(HB);
    sda_m = 1'b0; wclk(HB);
    scl_m = 1'b0; wclk(HB);
  endtask

  task automatic i_stop();
    sda_m = 1'b0; wclk(HB);
    scl_m = 1'b1; wclk(HB);
    sda_m = 1'b1; wclk(HB);
  endtask

  task automatic send_byte(input logic [7:0] b, output logic ack);
    for (int i = 7; i >= 0; i--) begin
      sda_m = b[i]; wclk(HB);
      scl_m = 1'b1; wclk(HB);
      scl_m = 1'b0;
    end
    sda_m = 1'b1; wclk(HB);
    scl_m = 1'b1; wclk(HB / 2);
    ack = bus_sda; wclk(HB / 2);
    scl_m = 1'b0;
  endtask

  task automatic recv_byte(input logic mack, output logic [7:0] b);
    for (int i = 7; i >= 0; i--) begin
      wclk(HB);
      scl_m = 1'b1; wclk(HB / 2);
      b[i] = bus_sda; wclk(HB / 2);
      scl_m = 1'b0;
    end
    sda_m = ~mack; wclk(HB);
    scl_m = 1'b1; wclk(HB);
    scl_m = 1'b0; sda_m = 1'b1;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog: actual=timeout expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks + 1);
      $finish;
    end
  end

  initial begin
    logic [15:0] d;
    logic ack;
    logic [7:0] b;
    wclk(4); rst = 1'b0; wclk(2);

    // R1 reset values
    rread(3'd0, d); check("R1 slot0", d, 16'h0036);
    for (int i = 1; i < 4; i++) begin
      rread(3'(i), d); check("R1 slotN", d, 16'h0000);
    end
    rread(O_CTRL, d); check("R1 ctrl", d, 16'h0000);
    rread(O_STAT, d); check("R1 status", d, 16'h0000);
    check("R1 irq", {15'd0, irq}, 16'h0000);

    // R2 reserved bits dropped
    rwrite(3'd1, 16'hABCD); rread(3'd1, d); check("R2 slot1 upper", d, 16'h00CD);

    // table: R3 R4 R5 R7
    rwrite(3'd1, 16'h00A0); rwrite(3'd2, 16'h00A0); rwrite(3'd3, 16'h0044);
    for (int v = 0; v < NV; v++) begin
      rwrite(O_CTRL, {11'd0, VEC[v][4], VEC[v][7:5]});
      rwrite(O_STAT, 16'h0001);
      i_start(); send_byte(VEC[v][15:8], ack); i_stop();
      check("R3/R5 ack", {15'd0, ack}, {15'd0, ~VEC[v][3]});
      rread(O_STAT, d);
      check("R7 flag", {15'd0, d[0]}, {15'd0, VEC[v][2]});
      if (VEC[v][2]) check("R4 index", {14'd0, d[2:1]}, {14'd0, VEC[v][1:0]});
    end

    // R7 W1C behaviour and R8 irq
    rwrite(O_CTRL, 16'h0000);
    i_start(); send_byte(8'h36, ack); i_stop();
    rwrite(O_STAT, 16'h0000); rread(O_STAT, d);
    check("R7 write0 keeps", {15'd0, d[0]}, 16'h0001);
    rwrite(O_CTRL, 16'h0010); wclk(3);
    check("R8 irq on", {15'd0, irq}, 16'h0001);
    rwrite(O_STAT, 16'h0001); wclk(3);
    check("R8 irq off", {15'd0, irq}, 16'h0000);
    rread(O_STAT, d); check("R7 cleared", {15'd0, d[0]}, 16'h0000);

    // R9 separate tx/rx
    rwrite(O_CTRL, 16'h0000);
    rwrite(O_DATA, 16'h00A5);
    i_start(); send_byte(8'h36, ack); send_byte(8'h3C, ack); i_stop();
    check("R9 data ack", {15'd0, ack}, 16'h0000);
    rread(O_DATA, d); check("R9 rx byte", d, 16'h003C);

    // R6 R10 read transfer on slot 3
    rwrite(O_CTRL, 16'h0004);
    i_start(); send_byte(8'h45, ack);
    check("R10 addr ack", {15'd0, ack}, 16'h0000);
    recv_byte(1'b1, b); check("R10 byte1", {8'd0, b}, 16'h00A5);
    recv_byte(1'b0, b); check("R10 byte2", {8'd0, b}, 16'h00A5);
    recv_byte(1'b0, b); check("R10 after nack", {8'd0, b}, 16'h00FF);
    i_stop();
    rread(3'd3, d); check("R6 slot3 rw", d, 16'h0045);
    rread(3'd0, d); check("R6 slot0 kept", d, 16'h0036);
    rread(3'd1, d); check("R6 slot1 kept", d, 16'h00A0);

    // R11 STOP ends addressed state
    rwrite(O_CTRL, 16'h0000);
    i_start(); send_byte(8'h36, ack); i_stop();
    send_byte(8'h77, ack);
    check("R11 no ack after stop", {15'd0, ack}, 16'h0001);
    i_stop();
    rread(O_DATA, d); check("R11 rx unchanged", d, 16'h003C);

    // R11 nacked read address: no data phase
    rwrite(O_DATA, 16'h0000);
    rwrite(O_CTRL, 16'h0008);
    i_start(); send_byte(8'h37, ack);
    check("R11 addr nack", {15'd0, ack}, 16'h0001);
    recv_byte(1'b0, b); check("R11 no data", {8'd0, b}, 16'h00FF);
    i_stop();
    rread(3'd0, d); check("R6 slot0 rw", d, 16'h0037);

    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule